// File: doc/BRIEF.md
# GPIO Port Controller with Interrupt Capture and Modem Handover

An eight-pin general-purpose I/O controller for a two-channel serial bridge. A small register interface with a 2-bit address gives access to four registers. These are the direction mask, the pin state, the interrupt mask and a control word. Pins that are outputs drive the levels held in the state register. Inputs are sampled through a two-flop synchronizer. A change on an enabled input raises a single interrupt line.

The interrupt works in one of two modes. In transparent mode it follows the difference between the live level and a snapshot taken at the last state read, so a pin that reverts withdraws its own request. In capture mode the first change on a pin is stored together with its new level. Both stay held until the state register is read. Each half of the port can be handed to one serial channel's modem-control signals. A control bit requests a one-cycle self-clearing reset of the register set.

Top module: `gpio_port`

## Requirements
- R1: After reset, all four registers read 0, no pin drives (pin_oe_o = 0) and irq_o is low.
- R2: Address map: 0 = direction, 1 = state, 2 = interrupt enable, 3 = control; the direction, enable and state-output values written are held and read back (direction and enable directly).
- R3: In GPIO mode, pin i drives (pin_oe_o[i] = 1) exactly when direction bit i is 1, and pin_o[i] equals state-output bit i.
- R4: A read of the state register returns the pin levels, which reach it two clock edges after a pin change, unless a captured value is held (R6).
- R5: With control bit 0 = 0 (transparent), irq_o is high while any enabled input differs from its level at the last state read. It drops when the pin reverts, or when the state register is read.
- R6: With control bit 0 = 1 (capture), an enabled input change sets irq_o and stores the new level in that state bit. Both persist when the pin reverts, until the state register is read. After that read the bit returns the live level.
- R7: A change on a pin whose enable bit is 0, or whose direction bit is 1, never raises irq_o.
- R8: Control bit 1 hands pins 7..4 to channel A, with pin 7 = ring, 6 = carrier, 5 = DTR and 4 = DSR. Ring, carrier and DSR never drive. They appear on mdm_ri_o[0], mdm_cd_o[0] and mdm_dsr_o[0], which read 1 when the nibble is not handed over. Pin 5 drives dtr_i[0] only when direction bit 5 is 1. Enable bits 7..4 have no effect.
- R9: Control bit 2 does the same for channel B on pins 3..0 (ring 3, carrier 2, DTR 1, DSR 0), using index 1 of the modem ports, dtr_i[1] and direction bit 1.
- R10: Writing 1 to control bit 3 clears direction, state-output, enable and control one cycle later. It also clears any pending interrupt. Bit 3 then reads 0, and control bits 7..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (a state read clears interrupts) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Pin output levels |
| pin_oe_o | output | 8 | Pin output enables |
| dtr_i | input | 2 | DTR level from channel A (bit 0) and channel B (bit 1) |
| mdm_ri_o | output | 2 | Ring level to channel A/B |
| mdm_cd_o | output | 2 | Carrier level to channel A/B |
| mdm_dsr_o | output | 2 | DSR level to channel A/B |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong change snapshot shows up at irq_o within three cycles of a pin toggle. Depending on the fault, the line stays high after a state read, rises on a masked or output pin, or fails to fall when a transparent input reverts. A capture fault shows at the next state read as a bit that carries the live level instead of the held one, or as irq_o dropping while the pin is back at its old level. A fault in the modem handover shows at once on pin_oe_o and pin_o, through a driving ring or carrier pin or DTR ignoring its direction bit. A reset pulse that leaves a register behind shows at the first read after the pulse.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DIR   = 2'd0,
    REG_STATE = 2'd1,
    REG_IEN   = 2'd2,
    REG_CTRL  = 2'd3
  } gpio_reg_e;

  localparam int CTL_CAPTURE = 0;
  localparam int CTL_MDM_A   = 1;
  localparam int CTL_MDM_B   = 2;
  localparam int CTL_SRST    = 3;
  localparam int CTL_W       = 3;

  // pin offsets inside a modem nibble
  localparam int MP_DSR = 0;
  localparam int MP_DTR = 1;
  localparam int MP_CD  = 2;
  localparam int MP_RI  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      ien_o,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic              srst_o
);
  logic [W-1:0]     dir_q, out_q, ien_q;
  logic [CTL_W-1:0] ctrl_q;
  logic             srst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else if (we_i) begin
      case (gpio_reg_e'(addr_i))
        REG_DIR:   dir_q <= wdata_i;
        REG_STATE: out_q <= wdata_i;
        REG_IEN:   ien_q <= wdata_i;
        REG_CTRL: begin
          ctrl_q <= wdata_i[CTL_W-1:0];
          srst_q <= wdata_i[CTL_SRST];
        end
        default: ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ien_o  = ien_q;
  assign ctrl_o = ctrl_q;
  assign srst_o = srst_q;

  assert_srst_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (!srst_q && dir_q == '0 && ien_q == '0 && ctrl_q == '0));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] en_i,
  input  logic         capture_i,
  input  logic         clr_i,
  output logic [W-1:0] view_o,
  output logic         irq_o
);
  logic [W-1:0] ref_q, hold_q, cap_q, chg;

  assign chg = (pin_s_i ^ ref_q) & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      hold_q <= '0;
      cap_q  <= '0;
    end else if (srst_i || clr_i) begin
      ref_q  <= pin_s_i;
      hold_q <= '0;
      cap_q  <= '0;
    end else if (!capture_i) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_q | chg;
      cap_q  <= (cap_q & hold_q) | (pin_s_i & chg & ~hold_q);
    end
  end

  assign view_o = (hold_q & cap_q) | (~hold_q & pin_s_i);
  assign irq_o  = capture_i ? |hold_q : |chg;

  assert_hold_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !clr_i && !srst_i) |=> ((hold_q & $past(hold_q)) == $past(hold_q)));
  assert_cap_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !clr_i && !srst_i) |=> (((cap_q ^ $past(cap_q)) & $past(hold_q)) == '0));
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || srst_i) |=> (hold_q == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8  // two modem nibbles: must be 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         re_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  input  logic [1:0]   dtr_i,
  output logic [1:0]   mdm_ri_o,
  output logic [1:0]   mdm_cd_o,
  output logic [1:0]   mdm_dsr_o,
  output logic         irq_o
);
  localparam int NIB = W / 2;

  logic [W-1:0]     dir, outv, ien, pin_s, view, mdm_mask, mdm_in_mask;
  logic [CTL_W-1:0] ctrl;
  logic             srst, clr;
  logic [1:0]       mdm_sel;

  gpio_sync #(.W(W)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .dir_o(dir), .out_o(outv), .ien_o(ien), .ctrl_o(ctrl), .srst_o(srst)
  );

  assign mdm_sel = {ctrl[CTL_MDM_B], ctrl[CTL_MDM_A]};  // index 0 = A (high nibble)
  assign clr     = re_i && (gpio_reg_e'(addr_i) == REG_STATE);

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam int POS = i % NIB;
    localparam int CH  = (i >= NIB) ? 0 : 1;
    localparam bit DTR = (POS == MP_DTR);
    assign mdm_mask[i]    = mdm_sel[CH];
    assign mdm_in_mask[i] = mdm_sel[CH] && !DTR;
    assign pin_oe_o[i]    = mdm_sel[CH] ? (DTR ? dir[i] : 1'b0) : dir[i];
    assign pin_o[i]       = mdm_sel[CH] ? (DTR ? dtr_i[CH] : 1'b0) : outv[i];
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam int BASE = (c == 0) ? NIB : 0;
    assign mdm_ri_o[c]  = mdm_sel[c] ? pin_s[BASE+MP_RI]  : 1'b1;
    assign mdm_cd_o[c]  = mdm_sel[c] ? pin_s[BASE+MP_CD]  : 1'b1;
    assign mdm_dsr_o[c] = mdm_sel[c] ? pin_s[BASE+MP_DSR] : 1'b1;
  end

  gpio_irq #(.W(W)) u_irq (
    .clk_i, .rst_ni, .srst_i(srst), .pin_s_i(pin_s),
    .en_i(ien & ~dir & ~mdm_mask), .capture_i(ctrl[CTL_CAPTURE]),
    .clr_i(clr), .view_o(view), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    case (gpio_reg_e'(addr_i))
      REG_DIR:   rdata_o = dir;
      REG_STATE: rdata_o = view;
      REG_IEN:   rdata_o = ien;
      REG_CTRL:  rdata_o[CTL_SRST:0] = {srst, ctrl};
      default: ;
    endcase
  end

  assert_mdm_in_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & mdm_in_mask) == '0);
  assert_srst_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !irq_o);
  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (pin_oe_o == '0));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic       clk = 0, rst_ni = 0, we = 0, re = 0;
  logic [1:0] addr = 0, dtr = 0;
  logic [7:0] wdata = 0, rdata, pins = 0, pin_o, pin_oe;
  logic [1:0] ri, cd, dsr;
  logic       irq;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  gpio_port u_dut (
    .clk_i(clk), .rst_ni, .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o, .pin_oe_o(pin_oe), .dtr_i(dtr),
    .mdm_ri_o(ri), .mdm_cd_o(cd), .mdm_dsr_o(dsr), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1; addr = a; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic setp(input logic [7:0] v);
    @(negedge clk); pins = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit irq_model(logic [7:0] p, logic [7:0] r, logic [7:0] en, logic [7:0] d);
    return |((p ^ r) & en & ~d);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, dv, ov, ev, refm;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk(d == 0, "R1 reg read", d, 0);
    end
    chk(pin_oe == 0, "R1 oe", pin_oe, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 / R3 register map, outputs
    wr(0, 8'hF0); wr(1, 8'hA5); wr(2, 8'h3C);
    rd(0, d); chk(d == 8'hF0, "R2 dir read", d, 8'hF0);
    rd(2, d); chk(d == 8'h3C, "R2 ien read", d, 8'h3C);
    chk(pin_oe == 8'hF0, "R3 oe", pin_oe, 8'hF0);
    chk(pin_o == 8'hA5, "R3 pin_o", pin_o, 8'hA5);

    // R4 state read reflects pins
    wr(0, 0); wr(2, 0);
    setp(8'h5A); rd(1, d); chk(d == 8'h5A, "R4 state read", d, 8'h5A);

    // R5 transparent
    setp(8'h00); wr(2, 8'h01); rd(1, d);
    setp(8'h01); chk(irq == 1, "R5 raise", irq, 1);
    setp(8'h00); chk(irq == 0, "R5 revert drops", irq, 0);
    setp(8'h01); chk(irq == 1, "R5 raise again", irq, 1);
    rd(1, d); chk(irq == 0, "R5 read clears", irq, 0);

    // R7 masked and output pins
    setp(8'h03); chk(irq == 0, "R7 disabled pin", irq, 0);
    wr(0, 8'h01); setp(8'h02); chk(irq == 0, "R7 output pin", irq, 0);
    wr(0, 0); setp(8'h00); rd(1, d);

    // R6 capture mode
    wr(3, 8'h01); wr(2, 8'h02); rd(1, d);
    setp(8'h02); chk(irq == 1, "R6 raise", irq, 1);
    setp(8'h00); chk(irq == 1, "R6 held after revert", irq, 1);
    rd(1, d); chk(d == 8'h02, "R6 captured value", d, 8'h02);
    chk(irq == 0, "R6 read clears", irq, 0);
    rd(1, d); chk(d == 8'h00, "R6 live after read", d, 0);

    // R10 reserved control bits
    wr(3, 8'hF1); rd(3, d); chk(d == 8'h01, "R10 reserved zero", d, 8'h01);

    // R8 channel A handover
    wr(3, 8'h02); wr(0, 8'hF0); wr(2, 8'hF0); dtr = 2'b01;
    setp(8'h00); rd(1, d);
    @(negedge clk);
    chk(pin_oe == 8'h20, "R8 oe only DTR", pin_oe, 8'h20);
    chk(pin_o[5] == 1, "R8 DTR follows", pin_o[5], 1);
    setp(8'h90); chk(irq == 0, "R8 ien ignored", irq, 0);
    chk(ri[0] == 1 && dsr[0] == 1 && cd[0] == 0, "R8 modem levels",
        {ri[0], cd[0], dsr[0]}, 3'b101);
    chk(ri[1] == 1 && cd[1] == 1 && dsr[1] == 1, "R8 B idle", {ri[1], cd[1], dsr[1]}, 3'b111);
    wr(0, 8'hD0); chk(pin_oe == 8'h00, "R8 DTR needs dir", pin_oe, 0);

    // R9 channel B handover
    wr(3, 8'h04); wr(0, 8'h02); dtr = 2'b10;
    setp(8'h0C); @(negedge clk);
    chk(pin_oe == 8'h02, "R9 oe only DTR", pin_oe, 8'h02);
    chk(pin_o[1] == 1, "R9 DTR follows", pin_o[1], 1);
    chk(ri[1] == 1 && cd[1] == 1 && dsr[1] == 0, "R9 modem levels",
        {ri[1], cd[1], dsr[1]}, 3'b110);

    // R10 reset request with pending capture
    wr(3, 8'h01); wr(0, 8'hF0); wr(1, 8'hFF); wr(2, 8'h01);
    setp(8'h00); rd(1, d); setp(8'h01);
    chk(irq == 1, "R10 pending before", irq, 1);
    wr(3, 8'h09); @(negedge clk);
    chk(irq == 0, "R10 irq cleared", irq, 0);
    chk(pin_oe == 0, "R10 oe cleared", pin_oe, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      if (a != 1) chk(d == 0, "R10 reg cleared", d, 0);
    end

    // random transparent traffic (R3 R4 R5 R7)
    rd(1, refm);
    for (int it = 0; it < 300; it++) begin
      dv = 8'($urandom); ov = 8'($urandom); ev = 8'($urandom);
      wr(0, dv); wr(1, ov); wr(2, ev);
      chk(pin_oe == dv, "R3 rand oe", pin_oe, dv);
      chk(pin_o == ov, "R3 rand pin_o", pin_o, ov);
      setp(8'($urandom));
      chk(irq == irq_model(pins, refm, ev, dv), "R5 rand irq", irq,
          irq_model(pins, refm, ev, dv));
      if (($urandom % 3) == 0) begin
        rd(1, d); chk(d == pins, "R4 rand state", d, pins);
        refm = pins;
        chk(irq == 0, "R5 rand read clears", irq, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule